// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block connects a synchronous host request port to a byte-wide asynchronous static RAM with a 20-bit address. The host offers one request at a time through a valid/ready handshake. Each request carries a write flag, an address and a write byte. The controller then drives the active-low chip enable, write enable and output enable, the address bus and a bidirectional data bus. It ends every access with a one-cycle done strobe, which carries the read byte for reads.

Each phase lasts a whole number of clock cycles. The counts are fixed at elaboration time from a speed-grade parameter and the clock period in nanoseconds. Each nanosecond minimum is rounded up to whole cycles, and every count is at least one. Writes are timed by write enable, and output enable stays high for the whole write. A recovery phase with both enables high follows every write.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and after it is released, chip enable, write enable and output enable are high, `req_ready` is high and `rsp_valid` is low.
- R2: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the first access cycle until the done cycle.
- R3: A read holds chip enable and output enable low and write enable high for RD cycles. RD is the largest of ceil(t_acc/T), ceil(t_oe/T) and ceil(t_rc/T). With grade 0 and T = 20 ns, RD is 4. The byte on the data bus is captured at the edge that ends the read. It is returned on `rsp_rdata` with `rsp_valid` high for one cycle, and both enables are high in that cycle.
- R4: A write holds chip enable and write enable low together for WP cycles, and output enable stays high. WP is the largest of ceil(t_wp/T), ceil(t_dw/T)+1 and ceil(t_aw/T). With grade 0 and T = 20 ns, WP is 4.
- R5: The controller drives the write byte onto the data bus from the second write cycle through the first cycle after write enable rises. It does not drive the bus in the first write cycle or at any other time.
- R6: After write enable rises, REC recovery cycles follow with both enables high, and then the done cycle. REC is max(ceil(t_wr/T), ceil(t_wc/T) - WP), which is 1 at grade 0. Write enable never falls in the cycle right after it rises.
- R7: The address bus holds the request address, unchanged, for every cycle in which chip enable is low.
- R8: When a new request is waiting in the done cycle, it is accepted at the next edge. Chip enable is then high for exactly that one done cycle between the two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle done strobe |
| rsp_rdata | output | 8 | Read byte, valid with the strobe of a read |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | 20 | Address bus |
| sram_dq | inout | 8 | Bidirectional data bus |

## Verification
The stimulus writes the all-zero, all-one and alternating byte patterns to the lowest, highest and scattered addresses, then reads them back. Because each address holds a different byte, a swapped address or a dropped write shows up as a wrong value. A read of a never-written address returns a fill byte computed from the address, which tells a real bus capture apart from stale register contents. The RAM stand-in in the bench puts the inverted byte on the bus until the access time has passed, so a read that ends too early captures the wrong value. Requests held valid back to back, and write-then-read of the same address, check the exact one-cycle turnaround and the recovery gap, while a cycle-exact reference queue checks the phase lengths.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int SPEED_GRADE = 0,
  parameter int CLK_NS      = 20,
  parameter int AW          = 20,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [AW-1:0] sram_addr,
  inout  wire  [DW-1:0] sram_dq
);

  function automatic int pick(input int g, input int a, input int b, input int c, input int d);
    case (g)
      0:       return a;
      1:       return b;
      2:       return c;
      default: return d;
    endcase
  endfunction

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_ACC = pick(SPEED_GRADE, 70, 85, 120, 150);
  localparam int T_OE  = pick(SPEED_GRADE, 35, 45, 60, 70);
  localparam int T_CYC = pick(SPEED_GRADE, 70, 85, 120, 150);
  localparam int T_WP  = pick(SPEED_GRADE, 55, 65, 85, 90);
  localparam int T_DW  = pick(SPEED_GRADE, 30, 35, 45, 50);
  localparam int T_AW  = pick(SPEED_GRADE, 65, 75, 100, 90);
  localparam int T_WR  = 5;

  localparam int RD_CYC  = imax(cyc(T_ACC), imax(cyc(T_OE), cyc(T_CYC)));
  localparam int WP_CYC  = imax(cyc(T_WP), imax(cyc(T_DW) + 1, cyc(T_AW)));
  localparam int REC_CYC = imax(cyc(T_WR), cyc(T_CYC) - WP_CYC);
  localparam int CNT_W   = $clog2(imax(RD_CYC, imax(WP_CYC, REC_CYC)) + 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_REC} state_t;

  state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0] wdat;
  logic          dq_oe;

  assign req_ready = (state == S_IDLE);
  assign sram_dq   = dq_oe ? wdat : {DW{1'bz}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      sram_ce_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_addr <= '0;
      wdat      <= '0;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          sram_addr <= req_addr;
          wdat      <= req_wdata;
          sram_ce_n <= 1'b0;
          sram_we_n <= !req_write;
          sram_oe_n <= req_write;
          cnt       <= '0;
          state     <= req_write ? S_WR : S_RD;
        end
        S_RD: if (cnt == CNT_W'(RD_CYC - 1)) begin
          rsp_rdata <= sram_dq;
          rsp_valid <= 1'b1;
          sram_ce_n <= 1'b1;
          sram_oe_n <= 1'b1;
          state     <= S_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_WR: begin
          dq_oe <= 1'b1;
          if (cnt == CNT_W'(WP_CYC - 1)) begin
            sram_ce_n <= 1'b1;
            sram_we_n <= 1'b1;
            cnt       <= '0;
            state     <= S_REC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          dq_oe <= 1'b0;
          if (cnt == CNT_W'(REC_CYC - 1)) begin
            rsp_valid <= 1'b1;
            state     <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

module sram_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic sram_ce_n,
  input logic sram_we_n,
  input logic sram_oe_n,
  input logic [19:0] sram_addr
);

  // R4
  oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

  // R4
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> !req_ready);

  // R3
  done_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (sram_ce_n && sram_oe_n && sram_we_n));

  // R6
  we_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |=> sram_we_n);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

endmodule

bind sram_ctl sram_ctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
  .sram_addr(sram_addr)
);

// File: tb/sram_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_ctl_tb_top;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + 19) / 20;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_N  = mx(cdiv(70), mx(cdiv(35), cdiv(70)));
  localparam int WP_N  = mx(cdiv(55), mx(cdiv(30) + 1, cdiv(65)));
  localparam int REC_N = mx(cdiv(5), cdiv(70) - WP_N);
  localparam int ACC_N = mx(cdiv(70), cdiv(35));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, ce_n, we_n, oe_n;
  logic [7:0] rsp_rdata;
  logic [19:0] sram_addr;
  wire  [7:0] dq;

  always #10 clk = ~clk;

  sram_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_ce_n(ce_n),
    .sram_we_n(we_n), .sram_oe_n(oe_n), .sram_addr(sram_addr), .sram_dq(dq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done_run = 0;

  function automatic logic [7:0] fill(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Cycle-level RAM stand-in
  logic [7:0] smem [int];
  logic [7:0] sm_out = '0;
  logic [7:0] latch = '0;
  int ce_cnt = 0, we_cnt = 0, gap = 0;
  bit wrote = 0;
  wire sm_drive = !ce_n && !oe_n && we_n;
  assign dq = sm_drive ? sm_out : 8'bz;

  always @(negedge clk) begin
    logic [7:0] v;
    if (!ce_n) ce_cnt++; else ce_cnt = 0;
    v = smem.exists(int'(sram_addr)) ? smem[int'(sram_addr)] : fill(sram_addr);
    sm_out = (ce_cnt >= ACC_N) ? v : ~v;
    if (rst_n && !we_n) begin
      if (we_cnt == 0 && wrote) check("R6", "recovery cycles before write", gap, (gap >= 1) ? gap : 1);
      we_cnt++;
      latch = dq;
    end else begin
      if (we_cnt > 0) begin
        check("R4", "write pulse cycles", we_cnt, WP_N);
        smem[int'(sram_addr)] = latch;
        wrote = 1;
        gap = 0;
      end
      we_cnt = 0;
      gap++;
    end
  end

  // Reference model: queue of expected per-cycle pin states
  typedef struct packed {
    logic ce, we, oe, drv, done, rdy, rd;
    logic [7:0]  data;
    logic [19:0] addr;
  } exp_t;
  exp_t q[$];
  logic [7:0] ref_mem [int];

  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) e = q.pop_front();
    else e = '{ce:1, we:1, oe:1, drv:0, done:0, rdy:1, rd:0, data:0, addr:0};
    if (!rst_n) begin
      check("R1", "reset ce_n", ce_n, 1);
      check("R1", "reset we_n", we_n, 1);
      check("R1", "reset oe_n", oe_n, 1);
      check("R1", "reset ready", req_ready, 1);
      check("R1", "reset rsp_valid", rsp_valid, 0);
    end else begin
      check(e.rd ? "R3" : "R4", "ce_n", ce_n, e.ce);
      check(e.rd ? "R3" : "R4", "we_n", we_n, e.we);
      check(e.rd ? "R3" : "R4", "oe_n", oe_n, e.oe);
      check("R2", "req_ready", req_ready, e.rdy);
      check(e.rd ? "R3" : "R6", "rsp_valid", rsp_valid, e.done);
      if (!e.ce) check("R7", "address", sram_addr, e.addr);
      if (e.drv) check("R5", "driven data", dq, e.data);
      if (e.done && e.rd) check("R3", "read data", rsp_rdata, e.data);
      if (req_valid && req_ready) begin
        exp_t s;
        s = '{ce:0, we:!req_write, oe:req_write, drv:0, done:0, rdy:0, rd:!req_write,
              data:req_wdata, addr:req_addr};
        if (!req_write) begin
          s.data = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : fill(req_addr);
          for (int i = 0; i < RD_N; i++) q.push_back(s);
        end else begin
          ref_mem[int'(req_addr)] = req_wdata;
          q.push_back(s);
          s.drv = 1;
          for (int i = 1; i < WP_N; i++) q.push_back(s);
          s.ce = 1; s.we = 1; s.oe = 1;
          q.push_back(s);
          s.drv = 0;
          for (int i = 1; i < REC_N; i++) q.push_back(s);
        end
        s = '{ce:1, we:1, oe:1, drv:0, done:1, rdy:1, rd:!req_write, data:s.data, addr:req_addr};
        q.push_back(s);
      end
    end
  end

  task automatic send(input logic wr, input logic [19:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic idle(input int n);
    @(posedge clk); #2;
    req_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic summary;
    if (!done_run) begin
      done_run = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(2);
    // R4 R5 R6: writes of distinct patterns to boundary and scattered addresses
    send(1, 20'h00000, 8'hA5); idle(3);
    send(1, 20'hFFFFF, 8'h5A); idle(1);
    send(1, 20'h12345, 8'h00);
    send(1, 20'h54321, 8'hFF);          // R8 back-to-back write
    // R3 R8: back-to-back reads
    send(0, 20'h00000, 8'h00);
    send(0, 20'hFFFFF, 8'h00);
    send(0, 20'h12345, 8'h00);
    send(0, 20'h54321, 8'h00);
    idle(2);
    send(0, 20'h0ABCD, 8'h00);          // R3 unwritten address
    send(1, 20'h00001, 8'h3C);          // write then read of same address
    send(0, 20'h00001, 8'h00);
    send(0, 20'h00000, 8'h00);          // R7 neighbour unaffected
    idle(20);
    check("R2", "queue drained", q.size(), 0);
    summary();
  end

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule